// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a CPU interrupt once a programmed number of visible video lines has gone by. The video timing logic gives it a one-cycle strobe at each line, together with the line number and a flag that says whether rendering is on. The CPU programs it with four register writes, and their addresses are decoded under the mask 0xE001. One write loads the down-counter directly. One loads the reload value. One arms the counter and one disarms it. Each of these writes also clears an interrupt that is waiting.

The block is driven by a three-state controller: `ST_OFF`, `ST_ARMED` and `ST_FIRED`. Reset puts it in `ST_OFF`. The transitions are:
- *enable* takes any state to `ST_ARMED`.
- *disable* takes any state to `ST_OFF`.
- *fire* takes `ST_ARMED` to `ST_FIRED` when the counter reaches zero at a qualified line.
- *acknowledge*, which is a counter or reload write, takes `ST_FIRED` back to `ST_ARMED`.

The interrupt output is a level that is high exactly while the controller is in `ST_FIRED`. While it is high the counter is frozen.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the interrupt output is low, and the counter, reload value, enable and pending flag are all zero. If the block is enabled straight after reset, the first qualified line fires it.
- R2: A write whose address ANDed with 0xE001 equals 0xC000 loads the counter with the written data and clears a pending interrupt.
- R3: A write whose address ANDed with 0xE001 equals 0xC001 loads the reload value and clears a pending interrupt.
- R4: A write whose address ANDed with 0xE001 equals 0xE000 disables counting and drops the interrupt output.
- R5: A write whose address ANDed with 0xE001 equals 0xE001 enables counting and clears a pending interrupt.
- R6: A line strobe acts only when the line number is between 0 and 239, rendering is on, counting is enabled and no interrupt is pending. Any other strobe leaves all state unchanged.
- R7: On line 0, a nonzero counter is decremented once before the zero check.
- R8: If the counter is zero at the check, the interrupt is raised one cycle after the strobe and the counter takes the reload value. In every acting strobe the counter then decrements once.
- R9: The counter is 8 bits wide. A decrement from 0 gives 255.
- R10: The interrupt output stays high until one of the four register writes clears it.
- R11: A decoded register write in the same cycle as a strobe takes priority, and that strobe is ignored. Writes whose address does not decode into the 0xC000–0xFFFF window have no effect. Mirrors such as 0xDFFE behave like their decoded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | DATA_W (8) | CPU write data |
| line_strobe | input | 1 | One-cycle pulse per video line |
| line_num | input | LINE_W (9) | Current line number |
| render_en | input | 1 | Rendering is on |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 9-bit line number and a last visible line of 239. With these values a full counter wrap takes only 256 strobes, so it fits in a short run. Line numbers of 240 and above can also be driven, which lets the bench probe the edge of the visible-line window from both sides. A behavioural model of the counter, written with plain integers, predicts the interrupt level on every clock. The bench compares that prediction with the output throughout the directed scenarios.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } sirq_state_e;

    typedef enum logic [2:0] {
        WR_NONE    = 3'd0,
        WR_COUNT   = 3'd1,
        WR_RELOAD  = 3'd2,
        WR_DISABLE = 3'd3,
        WR_ENABLE  = 3'd4
    } sirq_wr_e;

    localparam logic [15:0] DEC_MASK    = 16'hE001;
    localparam logic [15:0] ADR_COUNT   = 16'hC000;
    localparam logic [15:0] ADR_RELOAD  = 16'hC001;
    localparam logic [15:0] ADR_DISABLE = 16'hE000;
    localparam logic [15:0] ADR_ENABLE  = 16'hE001;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
(
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    output sirq_wr_e    wr_kind
);

    logic [15:0] masked;

    always_comb begin
        masked = wr_addr & DEC_MASK;
        wr_kind = WR_NONE;
        if (wr_en) begin
            unique case (masked)
                ADR_COUNT:   wr_kind = WR_COUNT;
                ADR_RELOAD:  wr_kind = WR_RELOAD;
                ADR_DISABLE: wr_kind = WR_DISABLE;
                ADR_ENABLE:  wr_kind = WR_ENABLE;
                default:     wr_kind = WR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sirq_line_gate.sv
module sirq_line_gate #(
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input  logic              line_strobe,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    output logic              visible,
    output logic              top_line
);

    localparam logic [LINE_W-1:0] LAST_L = LINE_W'(LAST_LINE);

    always_comb begin
        visible  = line_strobe && render_en && (line_num <= LAST_L);
        top_line = (line_num == '0);
    end

endmodule

// File: rtl/sirq_counter.sv
module sirq_counter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cnt,
    input  logic              load_rel,
    input  logic [DATA_W-1:0] data,
    input  logic              tick,
    input  logic              top_line,
    output logic              at_zero
);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] rel_q;
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] base;

    always_comb begin
        pre     = (top_line && (cnt_q != '0)) ? cnt_q - 1'b1 : cnt_q;
        at_zero = (pre == '0);
        base    = at_zero ? rel_q : pre;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= '0;
        end else begin
            if (load_rel) rel_q <= data;
            if (load_cnt)  cnt_q <= data;
            else if (tick) cnt_q <= base - 1'b1;
        end
    end

endmodule

// File: rtl/sirq_fsm.sv
module sirq_fsm
    import sirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sirq_wr_e wr_kind,
    input  logic     fire,
    output logic     armed,
    output logic     irq
);

    sirq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (wr_kind)
            WR_DISABLE: state_d = ST_OFF;
            WR_ENABLE:  state_d = ST_ARMED;
            WR_COUNT, WR_RELOAD:
                if (state_q == ST_FIRED) state_d = ST_ARMED;
            default:
                if (state_q == ST_ARMED && fire) state_d = ST_FIRED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == ST_ARMED);
        irq   = (state_q == ST_FIRED);
    end

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import sirq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_strobe,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    output logic              irq
);

    sirq_wr_e wr_kind;
    logic     visible, top_line, armed, at_zero, tick, fire;

    sirq_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_kind (wr_kind)
    );

    sirq_line_gate #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_gate (
        .line_strobe (line_strobe),
        .line_num    (line_num),
        .render_en   (render_en),
        .visible     (visible),
        .top_line    (top_line)
    );

    always_comb begin
        tick = visible && armed && (wr_kind == WR_NONE);
        fire = tick && at_zero;
    end

    sirq_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_cnt (wr_kind == WR_COUNT),
        .load_rel (wr_kind == WR_RELOAD),
        .data     (wr_data),
        .tick     (tick),
        .top_line (top_line),
        .at_zero  (at_zero)
    );

    sirq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_kind (wr_kind),
        .fire    (fire),
        .armed   (armed),
        .irq     (irq)
    );

endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
    parameter int DATA_W    = 8,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              line_strobe,
    input logic [LINE_W-1:0] line_num,
    input logic              render_en,
    input logic              irq
);

    logic reg_wr;
    logic [15:0] m_addr;
    assign m_addr = wr_addr & 16'hE001;
    assign reg_wr = wr_en && (wr_addr[15:14] == 2'b11);

    // R10: level held until a register write
    a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> irq);

    // R4: disable drops the output
    a_r4_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && m_addr == 16'hE000) |=> !irq);

    // R2: counter load clears pending
    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && m_addr == 16'hC000) |=> !irq);

    // R3: reload write clears pending
    a_r3_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && m_addr == 16'hC001) |=> !irq);

    // R5: enable clears pending
    a_r5_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && m_addr == 16'hE001) |=> !irq);

    // R6: no rise without a qualified strobe
    a_r6_no_offscreen_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && (!line_strobe || !render_en || line_num > LINE_W'(LAST_LINE)))
        |=> !irq);

endmodule

bind scanline_irq_counter sirq_checker #(
    .DATA_W(DATA_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE)
) u_chk (.*);

// File: tb/scanline_irq_counter_tb.sv
module scanline_irq_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_strobe = 1'b0;
    logic [8:0]  line_num = '0;
    logic        render_en = 1'b1;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt = 0, m_rel = 0;
    bit m_en = 0, m_pend = 0;

    always #10 clk = ~clk;

    scanline_irq_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_strobe(line_strobe), .line_num(line_num),
        .render_en(render_en), .irq(irq)
    );

    always @(posedge clk) begin
        int a;
        int c;
        a = wr_addr & 16'hE001;
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_en = 0; m_pend = 0;
        end else if (wr_en && (a == 16'hC000 || a == 16'hC001 ||
                               a == 16'hE000 || a == 16'hE001)) begin
            m_pend = 0;
            if (a == 16'hC000) m_cnt = wr_data;
            if (a == 16'hC001) m_rel = wr_data;
            if (a == 16'hE000) m_en = 0;
            if (a == 16'hE001) m_en = 1;
        end else if (line_strobe && render_en && line_num <= 239 && m_en && !m_pend) begin
            c = m_cnt;
            if (line_num == 0 && c != 0) c = c - 1;
            if (c == 0) begin
                m_pend = 1;
                c = m_rel;
            end
            m_cnt = (c + 255) % 256;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_pend) begin
                fails++;
                $display("FAIL %s model compare: irq=%0b expected=%0b", cur_req, irq, m_pend);
            end
        end
    end

    task automatic chk(input bit exp, input string req);
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s: irq=%0b expected=%0b", req, irq, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic line(input int n);
        line_strobe = 1'b1; line_num = 9'(n);
        @(negedge clk);
        line_strobe = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk(0, "R1 reset low");
        wr(16'hE001, 0);
        line(7);
        chk(1, "R1 zero counter after reset fires");

        cur_req = "R3";
        wr(16'hC001, 8'd3);
        chk(0, "R3 reload write clears pending");

        cur_req = "R8";
        wr(16'hC000, 8'd2);
        line(1); line(2);
        chk(0, "R8 not yet zero");
        line(3);
        chk(1, "R8 fires at zero");

        cur_req = "R10";
        line(4); line(5); repeat (3) @(negedge clk);
        chk(1, "R10 held while pending");

        cur_req = "R4";
        wr(16'hE000, 0);
        chk(0, "R4 disable drops irq");
        wr(16'hC000, 0);
        line(10);
        chk(0, "R4 disabled ignores lines");

        cur_req = "R7";
        wr(16'hE001, 0);
        wr(16'hC000, 8'd2);
        line(0);
        chk(0, "R7 line0 double decrement not zero");
        line(1);
        chk(1, "R7 fires after line0 double decrement");

        cur_req = "R5";
        wr(16'hE001, 0);
        chk(0, "R5 enable clears pending");

        cur_req = "R6";
        wr(16'hC000, 0);
        line(240);
        chk(0, "R6 line 240 ignored");
        render_en = 1'b0;
        line(20);
        chk(0, "R6 render off ignored");
        render_en = 1'b1;
        line(239);
        chk(1, "R6 line 239 acts");

        cur_req = "R9";
        wr(16'hC001, 0);
        wr(16'hC000, 0);
        line(5);
        chk(1, "R9 fire from zero");
        wr(16'hC001, 0);
        for (int i = 0; i < 255; i++) line(9);
        chk(0, "R9 after 255 lines counter at zero");
        line(9);
        chk(1, "R9 wrapped count fires on 256th line");

        cur_req = "R2";
        wr(16'hC000, 8'd1);
        chk(0, "R2 counter write clears pending");
        line(30);
        chk(0, "R2 loaded 1 decrements to 0");
        line(31);
        chk(1, "R2 fires after loaded count");

        cur_req = "R11";
        wr(16'hDFFE, 8'd0);
        chk(0, "R11 mirror address acts as counter write");
        wr(16'h8000, 8'd0);
        wr(16'h6000, 8'd0);
        wr(16'hC000, 8'd1);
        line_strobe = 1'b1; line_num = 9'd40;
        wr(16'hC000, 8'd0);
        line_strobe = 1'b0;
        chk(0, "R11 strobe with write ignored");
        line(41);
        chk(1, "R11 counter zero from write, next line fires");
        wr_en = 1'b1; wr_addr = 16'h8001; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        chk(1, "R11 non-decoded write leaves irq");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule